// File: doc/BRIEF.md
# Clause 22 MDIO Management Controller

This block is a memory-mapped management master for Clause 22 PHY register access. Software writes a single command word that carries the operation, the PHY address, the register address and, for writes, the data. That write launches one complete management frame on the MDC clock and the MDIO data line. On a read, the block releases the MDIO line from the turnaround onward, collects the 16 data bits the PHY returns, and posts them back into the same command word together with a read-valid flag. A busy flag is visible in the command word while the frame is in progress.

The end of every frame sets a completion cause bit. The interrupt output follows that bit only when software has set the same position in a mask register. Software clears the cause bit by writing 0 to its position. Writing 1 to that position has no effect. MDC is a divided copy of the system clock, and the division is set by the parameter `MDC_HALF`, which is the number of system clocks in each half period. Driven MDIO values change only on falling MDC edges. Returned data is taken on rising MDC edges.

The frame state machine has these states: `S_IDLE`, `S_ARM`, `S_PRE`, `S_ST`, `S_OP`, `S_PHY`, `S_REG`, `S_TA`, `S_DATA` and `S_DONE`. An accepted command moves `S_IDLE` to `S_ARM`. The first falling MDC edge after that moves `S_ARM` to `S_PRE`. From then on, each field state advances on the falling edge that closes its last bit, in the order `S_PRE`, `S_ST`, `S_OP`, `S_PHY`, `S_REG`, `S_TA`, `S_DATA`, `S_DONE`. `S_DONE` lasts one system clock, raises completion, and always returns to `S_IDLE`.

Top module: `mgmt_c22_ctrl`

## Requirements
- R1: After reset, the command word (offset 0x00), the cause register (0x7C) and the mask register (0x80) all read 0. The interrupt output is low and the MDIO driver enable is low.
- R2: Command word layout: data in bits 15:0, PHY address in bits 20:16, register address in bits 25:21, operation in bit 26 (1 = read, 0 = write), read-valid in bit 27, busy in bit 28. Bits 31:29 read 0. An accepted command reads back its written fields with busy = 1.
- R3: A write frame drives 64 bits MSB first, each sampled on a rising MDC edge: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register address, turnaround 10, then the 16 data bits. The enable is high for all 64 bits. MDIO and its enable change only in the system clock that follows a falling MDC edge.
- R4: A read frame drives 32 ones, start 01, opcode 10, the PHY address and the register address (46 bits). It releases the enable for the 2 turnaround bits and the 16 data bits. It samples MDIO on the rising MDC edge of each data bit, MSB first. At completion, bits 15:0 hold the received value and bit 27 is 1.
- R5: Busy stays 1 from command acceptance until the frame completes, then returns to 0.
- R6: A command write that arrives while busy is 1 is ignored. The frame on the wire and the stored fields stay those of the running command.
- R7: An accepted command clears read-valid (bit 27).
- R8: Completion of any frame sets bit 4 of the cause register (0x7C). Writing 0 to bit 4 clears it, and writing 1 to bit 4 leaves it set.
- R9: The mask register (0x80) stores bit 4 and reads back at bit 4. The interrupt output is high exactly when cause bit 4 and mask bit 4 are both 1.
- R10: MDC toggles every `MDC_HALF` system clocks, so its period is 2·`MDC_HALF` system clocks.
- R11: Reads from any address other than 0x00, 0x7C and 0x80 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO driver enable (1 = block drives) |
| mdio_i | input | 1 | MDIO value seen on the line |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions run on every cycle and check the following:
- MDC holds its level between divider wraps.
- The MDIO pins move only after a falling MDC edge.
- The driver stays released while a read is in turnaround or in the data field.
- Busy falls only out of the completion state.
- A busy-time command write leaves the stored fields untouched.
- A new command clears read-valid.
- The cause bit rises only on completion and survives a write of 1.

Only the bench scenarios can show:
- the bit-exact content of write and read frames against an independent PHY model;
- the returned data landing in bits 15:0;
- the interrupt gating through the mask;
- the reset values;
- the measured MDC period.

// File: rtl/mgmt_c22_pkg.sv
package mgmt_c22_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARM,
        S_PRE,
        S_ST,
        S_OP,
        S_PHY,
        S_REG,
        S_TA,
        S_DATA,
        S_DONE
    } frame_state_e;

    // Field lengths of one management frame, in MDC bits
    localparam int PRE_LEN = 32;
    localparam int ST_LEN  = 2;
    localparam int OP_LEN  = 2;
    localparam int ADR_LEN = 5;
    localparam int TA_LEN  = 2;
    localparam int DAT_LEN = 16;
    localparam int CNT_W   = $clog2(PRE_LEN);

    // Register word layout
    localparam int REG_W        = 32;
    localparam int F_DATA_LSB   = 0;
    localparam int F_PHY_LSB    = 16;
    localparam int F_REG_LSB    = 21;
    localparam int F_OP_BIT     = 26;
    localparam int F_RVALID_BIT = 27;
    localparam int F_BUSY_BIT   = 28;

    // Interrupt layout
    localparam int DONE_CAUSE_BIT = 4;

    // Register byte offsets
    localparam int CMD_OFS   = 'h00;
    localparam int CAUSE_OFS = 'h7C;
    localparam int MASK_OFS  = 'h80;

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
    parameter int MDC_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(MDC_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Strobes mark the system clock whose edge moves MDC
    assign rise_stb = wrap & ~mdc;
    assign fall_stb = wrap & mdc;

    // R10
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mdc));

endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_c22_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_stb,
    input  logic         rise_stb,
    input  logic         start,
    input  logic         op_rd,
    input  logic [4:0]   phy_ad,
    input  logic [4:0]   reg_ad,
    input  logic [15:0]  wdata,
    input  logic         mdio_i,
    output logic         mdio_o,
    output logic         mdio_oe,
    output logic         busy,
    output logic         done,
    output logic [15:0]  rd_data
);
    frame_state_e      state, nxt;
    logic [CNT_W-1:0]  cnt_q, nxt_cnt;
    logic [15:0]       rd_sh;
    logic [2:0]        adr_idx;
    logic [3:0]        dat_idx;

    // Advance one field bit; move to succ after the field's last bit
    function automatic void step(input frame_state_e cur, input logic [CNT_W-1:0] c,
                                 input int len, input frame_state_e succ,
                                 output frame_state_e ns, output logic [CNT_W-1:0] nc);
        if (c == CNT_W'(len - 1)) begin
            ns = succ;
            nc = '0;
        end else begin
            ns = cur;
            nc = c + 1'b1;
        end
    endfunction

    always_comb begin
        nxt     = state;
        nxt_cnt = cnt_q;
        unique case (state)
            S_IDLE: if (start) nxt = S_ARM;
            S_ARM:  if (fall_stb) begin
                        nxt     = S_PRE;
                        nxt_cnt = '0;
                    end
            S_PRE:  if (fall_stb) step(state, cnt_q, PRE_LEN, S_ST,   nxt, nxt_cnt);
            S_ST:   if (fall_stb) step(state, cnt_q, ST_LEN,  S_OP,   nxt, nxt_cnt);
            S_OP:   if (fall_stb) step(state, cnt_q, OP_LEN,  S_PHY,  nxt, nxt_cnt);
            S_PHY:  if (fall_stb) step(state, cnt_q, ADR_LEN, S_REG,  nxt, nxt_cnt);
            S_REG:  if (fall_stb) step(state, cnt_q, ADR_LEN, S_TA,   nxt, nxt_cnt);
            S_TA:   if (fall_stb) step(state, cnt_q, TA_LEN,  S_DATA, nxt, nxt_cnt);
            S_DATA: if (fall_stb) step(state, cnt_q, DAT_LEN, S_DONE, nxt, nxt_cnt);
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt_q <= '0;
        end else begin
            state <= nxt;
            cnt_q <= nxt_cnt;
        end
    end

    assign adr_idx = 3'(ADR_LEN - 1) - nxt_cnt[2:0];
    assign dat_idx = 4'(DAT_LEN - 1) - nxt_cnt[3:0];

    // Output register: the bit of the slot that a falling edge opens
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (fall_stb) begin
            unique case (nxt)
                S_PRE: begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end
                S_ST: begin
                    mdio_o  <= nxt_cnt[0];
                    mdio_oe <= 1'b1;
                end
                S_OP: begin
                    mdio_o  <= op_rd ? ~nxt_cnt[0] : nxt_cnt[0];
                    mdio_oe <= 1'b1;
                end
                S_PHY: begin
                    mdio_o  <= phy_ad[adr_idx];
                    mdio_oe <= 1'b1;
                end
                S_REG: begin
                    mdio_o  <= reg_ad[adr_idx];
                    mdio_oe <= 1'b1;
                end
                S_TA: begin
                    mdio_o  <= ~nxt_cnt[0];
                    mdio_oe <= ~op_rd;
                end
                S_DATA: begin
                    mdio_o  <= wdata[dat_idx];
                    mdio_oe <= ~op_rd;
                end
                default: begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                end
            endcase
        end
    end

    // Capture of returned data on rising MDC, MSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sh <= '0;
        end else if (rise_stb && state == S_DATA && op_rd) begin
            rd_sh <= {rd_sh[14:0], mdio_i};
        end
    end

    assign rd_data = rd_sh;
    assign busy    = (state != S_IDLE);
    assign done    = (state == S_DONE);

    // R3
    pin_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> $past(fall_stb));

    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_DATA || state == S_TA) && op_rd) |-> !mdio_oe);

    // R5
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

// File: rtl/mgmt_irq_unit.sv
module mgmt_irq_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic cause_wr,
    input  logic cause_wbit,
    input  logic mask_wr,
    input  logic mask_wbit,
    output logic cause_q,
    output logic mask_q,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= 1'b0;
        end else if (done) begin
            cause_q <= 1'b1;
        end else if (cause_wr && !cause_wbit) begin
            cause_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (mask_wr) begin
            mask_q <= mask_wbit;
        end
    end

    assign irq = cause_q & mask_q;

    // R8
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q) |-> $past(done));

    // R8
    cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q && cause_wr && cause_wbit) |=> cause_q);

endmodule

// File: rtl/mgmt_c22_ctrl.sv
module mgmt_c22_ctrl
    import mgmt_c22_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int MDC_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              irq
);
    logic        rise_stb, fall_stb;
    logic        busy, done, start;
    logic        sel_cmd, sel_cause, sel_mask;
    logic        cmd_op, cmd_rvalid;
    logic [4:0]  cmd_phy, cmd_reg;
    logic [15:0] cmd_data, rd_data;
    logic        cause_q, mask_q;
    logic        unused_wbits;

    assign sel_cmd   = (reg_addr == ADDR_W'(CMD_OFS));
    assign sel_cause = (reg_addr == ADDR_W'(CAUSE_OFS));
    assign sel_mask  = (reg_addr == ADDR_W'(MASK_OFS));
    assign start     = reg_wr && sel_cmd && !busy;
    assign unused_wbits = ^reg_wdata[REG_W-1:F_OP_BIT+1];

    mgmt_mdc_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mgmt_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .start    (start),
        .op_rd    (cmd_op),
        .phy_ad   (cmd_phy),
        .reg_ad   (cmd_reg),
        .wdata    (cmd_data),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy),
        .done     (done),
        .rd_data  (rd_data)
    );

    mgmt_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .cause_wr   (reg_wr && sel_cause),
        .cause_wbit (reg_wdata[DONE_CAUSE_BIT]),
        .mask_wr    (reg_wr && sel_mask),
        .mask_wbit  (reg_wdata[DONE_CAUSE_BIT]),
        .cause_q    (cause_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    // Command word storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_op     <= 1'b0;
            cmd_phy    <= '0;
            cmd_reg    <= '0;
            cmd_data   <= '0;
            cmd_rvalid <= 1'b0;
        end else if (start) begin
            cmd_op     <= reg_wdata[F_OP_BIT];
            cmd_phy    <= reg_wdata[F_PHY_LSB +: 5];
            cmd_reg    <= reg_wdata[F_REG_LSB +: 5];
            cmd_data   <= reg_wdata[F_DATA_LSB +: 16];
            cmd_rvalid <= 1'b0;
        end else if (done && cmd_op) begin
            cmd_data   <= rd_data;
            cmd_rvalid <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_cmd) begin
            reg_rdata[F_DATA_LSB +: 16] = cmd_data;
            reg_rdata[F_PHY_LSB +: 5]   = cmd_phy;
            reg_rdata[F_REG_LSB +: 5]   = cmd_reg;
            reg_rdata[F_OP_BIT]         = cmd_op;
            reg_rdata[F_RVALID_BIT]     = cmd_rvalid;
            reg_rdata[F_BUSY_BIT]       = busy;
        end else if (sel_cause) begin
            reg_rdata[DONE_CAUSE_BIT]   = cause_q;
        end else if (sel_mask) begin
            reg_rdata[DONE_CAUSE_BIT]   = mask_q;
        end
    end

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && sel_cmd) |=> $stable({cmd_op, cmd_phy, cmd_reg}));

    // R7
    rvalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !cmd_rvalid);

endmodule

// File: tb/mgmt_c22_ctrl_tb.sv
`timescale 1ns/1ps
module mgmt_c22_ctrl_tb;
    localparam int HALF   = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mdc, mdio_o, mdio_oe, irq;
    logic              mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // frame capture by the PHY model
    logic        cap_arm = 1'b0;
    int          cap_idx = 0;
    logic [63:0] cap_bit;
    logic [63:0] cap_oe;
    logic [15:0] phy_val = 16'h0000;

    mgmt_c22_ctrl #(.ADDR_W(ADDR_W), .MDC_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // PHY model: record each bit at rising MDC once the frame has begun
    always @(posedge mdc) begin
        #1;
        if (cap_arm && cap_idx < 64 && (cap_idx > 0 || mdio_oe)) begin
            cap_bit[63-cap_idx] = mdio_oe ? mdio_o : 1'b0;
            cap_oe[63-cap_idx]  = mdio_oe;
            cap_idx = cap_idx + 1;
        end
    end

    // PHY model: drive turnaround zero and read data after falling MDC
    always @(negedge mdc) begin
        #1;
        if (cap_arm && cap_idx == 47)
            mdio_i = 1'b0;
        else if (cap_arm && cap_idx >= 48 && cap_idx <= 63)
            mdio_i = phy_val[63-cap_idx];
        else
            mdio_i = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 5000; i++) begin
            reg_read(8'h00, d);
            if (!d[28]) break;
        end
    endtask

    task automatic wait_capture();
        for (int i = 0; i < 5000; i++) begin
            if (cap_idx >= 64) break;
            @(negedge clk);
        end
        cap_arm = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
        return {5'b0, rd, rg, phy, d};
    endfunction

    function automatic logic [63:0] frame(input bit rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

    task automatic arm();
        cap_idx = 0;
        cap_arm = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(8'h00, d); check(d == 32'h0, "R1 cmd reset", {32'h0, d}, 64'h0);
        reg_read(8'h7C, d); check(d == 32'h0, "R1 cause reset", {32'h0, d}, 64'h0);
        reg_read(8'h80, d); check(d == 32'h0, "R1 mask reset", {32'h0, d}, 64'h0);
        check(irq == 1'b0 && mdio_oe == 1'b0, "R1 pins reset", {62'h0, irq, mdio_oe}, 64'h0);
        reg_read(8'h44, d); check(d == 32'h0, "R11 unmapped read", {32'h0, d}, 64'h0);
    endtask

    task automatic t_mdc_period();
        realtime t0, t1;
        @(posedge mdc); t0 = $realtime;
        @(posedge mdc); t1 = $realtime;
        check((t1 - t0) == real'(2 * HALF * 20), "R10 mdc period",
              64'(int'(t1 - t0)), 64'(2 * HALF * 20));
    endtask

    task automatic t_write_frame(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        logic [31:0] r;
        logic [31:0] w;
        w = cmd_word(1'b0, phy, rg, d);
        arm();
        reg_write(8'h00, w);
        reg_read(8'h00, r);
        check(r == (w | 32'h1000_0000), "R2 cmd echo busy", {32'h0, r}, {32'h0, w | 32'h1000_0000});
        wait_capture();
        check(cap_bit == frame(1'b0, phy, rg, d), "R3 write frame bits", cap_bit, frame(1'b0, phy, rg, d));
        check(cap_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R3 write frame enable", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        wait_idle();
        reg_read(8'h00, r);
        check(r == w, "R5 busy cleared after write", {32'h0, r}, {32'h0, w});
        reg_read(8'h7C, r);
        check(r == 32'h10, "R8 cause set on write done", {32'h0, r}, 64'h10);
    endtask

    task automatic t_read_frame(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
        logic [31:0] r;
        logic [31:0] w;
        logic [63:0] m;
        w = cmd_word(1'b1, phy, rg, 16'h0);
        m = 64'hFFFF_FFFF_FFFC_0000;
        phy_val = v;
        arm();
        reg_write(8'h00, w);
        wait_capture();
        check((cap_bit & m) == (frame(1'b1, phy, rg, 16'h0) & m), "R4 read frame header",
              cap_bit & m, frame(1'b1, phy, rg, 16'h0) & m);
        check(cap_oe == m, "R4 read release", cap_oe, m);
        wait_idle();
        reg_read(8'h00, r);
        check(r == ({5'b0, 1'b1, 1'b1, rg, phy, v}), "R4 read result and valid",
              {32'h0, r}, {32'h0, 5'b0, 1'b1, 1'b1, rg, phy, v});
    endtask

    task automatic t_ignore_busy();
        logic [31:0] r;
        logic [31:0] a;
        logic [31:0] b;
        a = cmd_word(1'b0, 5'h0C, 5'h03, 16'h1234);
        b = cmd_word(1'b1, 5'h1F, 5'h1F, 16'hFFFF);
        arm();
        reg_write(8'h00, a);
        repeat (20) @(negedge clk);
        reg_write(8'h00, b);
        reg_read(8'h00, r);
        check(r == (a | 32'h1000_0000), "R6 busy write ignored fields", {32'h0, r}, {32'h0, a | 32'h1000_0000});
        wait_capture();
        check(cap_bit == frame(1'b0, 5'h0C, 5'h03, 16'h1234), "R6 frame unchanged",
              cap_bit, frame(1'b0, 5'h0C, 5'h03, 16'h1234));
        wait_idle();
        reg_read(8'h00, r);
        check(r == a, "R6 stored command after done", {32'h0, r}, {32'h0, a});
    endtask

    task automatic t_rvalid_clear();
        logic [31:0] r;
        reg_read(8'h00, r);
        check(r[27] == 1'b1, "R7 valid before new cmd", {63'h0, r[27]}, 64'h1);
        arm();
        reg_write(8'h00, cmd_word(1'b0, 5'h02, 5'h04, 16'h0F0F));
        reg_read(8'h00, r);
        check(r[27] == 1'b0 && r[28] == 1'b1, "R7 valid cleared by new cmd",
              {62'h0, r[28], r[27]}, 64'h2);
        wait_capture();
        wait_idle();
    endtask

    task automatic t_irq();
        logic [31:0] r;
        reg_write(8'h80, 32'h0);
        check(irq == 1'b0, "R9 masked irq low", {63'h0, irq}, 64'h0);
        reg_write(8'h7C, 32'hFFFF_FFFF);
        reg_read(8'h7C, r);
        check(r == 32'h10, "R8 write one keeps cause", {32'h0, r}, 64'h10);
        reg_write(8'h80, 32'h10);
        reg_read(8'h80, r);
        check(r == 32'h10, "R9 mask readback", {32'h0, r}, 64'h10);
        check(irq == 1'b1, "R9 irq when masked in", {63'h0, irq}, 64'h1);
        reg_write(8'h7C, ~32'h10);
        reg_read(8'h7C, r);
        check(r == 32'h0, "R8 write zero clears cause", {32'h0, r}, 64'h0);
        check(irq == 1'b0, "R9 irq low after clear", {63'h0, irq}, 64'h0);
        arm();
        reg_write(8'h00, cmd_word(1'b1, 5'h07, 5'h01, 16'h0));
        check(irq == 1'b0, "R9 irq low while busy", {63'h0, irq}, 64'h0);
        wait_capture();
        wait_idle();
        check(irq == 1'b1, "R9 irq after read done", {63'h0, irq}, 64'h1);
        reg_write(8'h80, 32'h0);
        check(irq == 1'b0, "R9 irq low when mask cleared", {63'h0, irq}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mdc_period();
        t_write_frame(5'h13, 5'h0A, 16'hA5C3);
        t_write_frame(5'h00, 5'h1F, 16'h8001);
        t_read_frame(5'h01, 5'h1F, 16'h3C5A);
        t_read_frame(5'h1E, 5'h00, 16'h8001);
        t_rvalid_clear();
        t_ignore_busy();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule